// File: doc/BRIEF.md
# Paravirtual Queue Device Register Front-End

This block is the register face of a paravirtual I/O device. A host bus master reaches it through a simple one-cycle request port, with byte, halfword or word accesses. Behind that port are a read-only feature mask the device offers and a read/write feature mask the driver accepts. There is a page-frame register and a size register for each queue, chosen through a queue selector. There is also a doorbell, an 8-bit device status register and an 8-bit interrupt status register that clears when read. Offsets from 20 upward go out to a device-specific configuration window, with the offset rebased to zero.

The device side sees the accepted feature mask and the physical base address of every queue, which is the page frame shifted up by 12 bits. It also gets a one-cycle kick pulse carrying the queue index written to the doorbell, and a one-cycle reset pulse when the driver writes zero to the status register. Device logic raises interrupt causes through a per-bit set strobe. The interrupt line follows bit 0 of the interrupt status register.

Top module: `pvq_regs`

## Requirements
- R1: After synchronous reset, every stored register is zero (feature masks, page frames, selector, status, interrupt status), the interrupt line is low and no kick or reset pulse is active.
- R2: A read at offset 0 returns the host feature input with bit 24 (notify-on-empty) forced to 1. Writes at offset 0 have no effect.
- R3: Offset 4 holds the guest feature mask (read/write). Its value is driven on `guest_feat_o`.
- R4: Offset 8 holds the page frame of the selected queue. A read returns the stored frame, and `q_base_o` slice q equals that queue's frame followed by 12 zero bits. Writing offset 8 leaves the queue selection unchanged.
- R5: A read at offset 12 returns the 16-bit size input of the selected queue (slice q of `q_size_i`). Writes there have no effect.
- R6: Offset 14 is the queue selector. A written value below NQ (default 4) is stored. Any other value is ignored and the old selection is kept.
- R7: A write at offset 16 raises `kick_o` for exactly the one cycle after the access, with `kick_idx_o` equal to the low 16 bits of the written value. A read at offset 16 returns all ones.
- R8: Offset 18 stores the low 8 bits of the written value as device status.
- R9: Writing a value whose low 8 bits are zero to offset 18 clears the guest features, all page frames, the selector and the interrupt status. It also pulses `dev_reset_o` for the one cycle after the access.
- R10: A read at offset 19 returns the interrupt status and clears it. Bits set through `isr_set_i` in the same cycle survive the clear. `irq_o` always equals bit 0 of the interrupt status. Writes at offset 19 have no effect.
- R11: An access at offset 20 to 20+CFG_LEN-1 asserts `cfg_valid_o` in that cycle, with `cfg_off_o` equal to the offset minus 20 and the size and masked write data passed through. A read there returns `cfg_rdata_i`.
- R12: The region spans 20+CFG_LEN rounded up to a power of two (32 bytes by default). Reads of any offset not listed above (for example 1, 5, 28 to 31 by default) return all ones, and writes there change nothing.
- R13: The size code is 0 for a byte, 1 for a halfword and 2 or 3 for a word. Read data is zero-extended from the access width, and writes use only the low access-width bits. Read data appears on `rsp_rdata` one cycle after the request, with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (5) | Byte offset in the region |
| req_size | input | 2 | Access width code |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| host_feat_i | input | 32 | Feature mask offered by the device |
| q_size_i | input | NQ*16 | Per-queue size, queue 0 in the low slice |
| isr_set_i | input | 8 | Interrupt status set strobes |
| cfg_valid_o | output | 1 | Configuration window access |
| cfg_write_o | output | 1 | Configuration access is a write |
| cfg_off_o | output | CFG_OFF_W (3) | Offset inside the configuration window |
| cfg_size_o | output | 2 | Configuration access width code |
| cfg_wdata_o | output | 32 | Configuration write data, width-masked |
| cfg_rdata_i | input | 32 | Configuration read data, same cycle |
| guest_feat_o | output | 32 | Accepted feature mask |
| q_base_o | output | NQ*44 | Per-queue physical base address |
| dev_status_o | output | 8 | Device status |
| irq_o | output | 1 | Interrupt line |
| kick_o | output | 1 | Doorbell pulse |
| kick_idx_o | output | 16 | Queue index carried by the doorbell |
| dev_reset_o | output | 1 | Device reset pulse |

## Verification
The bench goes after selector writes at and above the queue count. A design that took them would move page-frame traffic onto a queue that does not exist. It also targets a page-frame write with an out-of-range value, where a design that fell through into the selector would switch queues. It lands an interrupt set strobe on the very cycle of an interrupt status read, and a design that let the clear win would lose that event and drop the interrupt line. Narrow writes, reads of holes in the map (including the doorbell and the tail past the configuration window), and status writes whose low byte alone is zero are all checked. A design that got these wrong would leak upper bits, return stale data, or miss the device reset.

// File: rtl/pvq_pkg.sv
package pvq_pkg;
  localparam int DATA_W     = 32;
  localparam int CFG_BASE   = 20;
  localparam int PAGE_SHIFT = 12;
  localparam int QSIZE_W    = 16;
  localparam int ISR_W      = 8;

  typedef enum logic [3:0] {
    K_HOSTF, K_GUESTF, K_PFN, K_QSIZE, K_QSEL,
    K_KICK, K_STATUS, K_ISR, K_CFG, K_NONE
  } reg_kind_e;

  function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pvq_decode.sv
module pvq_decode
  import pvq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CFG_LEN   = 8,
  parameter int CFG_OFF_W = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  output reg_kind_e            kind,
  output logic [CFG_OFF_W-1:0] cfg_off
);
  logic [31:0] a;
  assign a       = 32'(addr);
  assign cfg_off = CFG_OFF_W'(a - 32'(CFG_BASE));

  always_comb begin
    case (a)
      32'd0:   kind = K_HOSTF;
      32'd4:   kind = K_GUESTF;
      32'd8:   kind = K_PFN;
      32'd12:  kind = K_QSIZE;
      32'd14:  kind = K_QSEL;
      32'd16:  kind = K_KICK;
      32'd18:  kind = K_STATUS;
      32'd19:  kind = K_ISR;
      default: kind = (a >= 32'(CFG_BASE) && a < 32'(CFG_BASE + CFG_LEN)) ? K_CFG : K_NONE;
    endcase
  end
endmodule

// File: rtl/pvq_queue_file.sv
module pvq_queue_file
  import pvq_pkg::*;
#(
  parameter int NQ     = 4,
  parameter int SEL_W  = 2,
  parameter int BASE_W = DATA_W + PAGE_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 wr_sel,
  input  logic                 wr_pfn,
  input  logic [DATA_W-1:0]    wval,
  output logic [SEL_W-1:0]     sel,
  output logic [DATA_W-1:0]    rd_pfn,
  output logic [NQ*BASE_W-1:0] base
);
  logic [DATA_W-1:0] pfn_q [NQ];
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk) begin
    if (rst || clear)                 sel_q <= '0;
    else if (wr_sel && wval < 32'(NQ)) sel_q <= SEL_W'(wval);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_ff @(posedge clk) begin
      if (rst || clear)                        pfn_q[q] <= '0;
      else if (wr_pfn && sel_q == SEL_W'(q))   pfn_q[q] <= wval;
    end
    assign base[q*BASE_W +: BASE_W] = {pfn_q[q], {PAGE_SHIFT{1'b0}}};
  end

  assign sel    = sel_q;
  assign rd_pfn = pfn_q[sel_q];

  // R6: out-of-range selector write keeps the old selection
  assert_sel_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wval >= 32'(NQ) && !clear) |=> sel_q == $past(sel_q));
  // R4: page frame write does not move the selector
  assert_pfn_keeps_sel_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_pfn && !clear) |=> sel_q == $past(sel_q));
endmodule

// File: rtl/pvq_isr.sv
module pvq_isr
  import pvq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             rd_clr,
  input  logic [ISR_W-1:0] set,
  output logic [ISR_W-1:0] isr,
  output logic             irq
);
  logic [ISR_W-1:0] isr_q;

  always_ff @(posedge clk) begin
    if (rst) isr_q <= '0;
    else     isr_q <= ((clear || rd_clr) ? '0 : isr_q) | set;
  end

  assign isr = isr_q;
  assign irq = isr_q[0];

  // R10: a read with no concurrent set leaves the register empty
  assert_rdclr_empty_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && set == '0) |=> isr_q == '0);
  // R10: a set strobe is never lost, even against a clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> (isr_q & $past(set)) == $past(set));
endmodule

// File: rtl/pvq_regs.sv
module pvq_regs
  import pvq_pkg::*;
#(
  parameter int NQ        = 4,
  parameter int CFG_LEN   = 8,
  parameter int NOE_BIT   = 24,
  localparam int REGION   = 1 << $clog2(CFG_BASE + CFG_LEN),
  localparam int ADDR_W   = $clog2(REGION),
  localparam int CFG_OFF_W = (CFG_LEN > 1) ? $clog2(CFG_LEN) : 1,
  localparam int SEL_W    = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int BASE_W   = DATA_W + PAGE_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic [DATA_W-1:0]       host_feat_i,
  input  logic [NQ*QSIZE_W-1:0]   q_size_i,
  input  logic [ISR_W-1:0]        isr_set_i,
  output logic                    cfg_valid_o,
  output logic                    cfg_write_o,
  output logic [CFG_OFF_W-1:0]    cfg_off_o,
  output logic [1:0]              cfg_size_o,
  output logic [DATA_W-1:0]       cfg_wdata_o,
  input  logic [DATA_W-1:0]       cfg_rdata_i,
  output logic [DATA_W-1:0]       guest_feat_o,
  output logic [NQ*BASE_W-1:0]    q_base_o,
  output logic [7:0]              dev_status_o,
  output logic                    irq_o,
  output logic                    kick_o,
  output logic [15:0]             kick_idx_o,
  output logic                    dev_reset_o
);
  reg_kind_e            kind;
  logic [CFG_OFF_W-1:0] cfg_off;
  logic [DATA_W-1:0]    wmask, wval, rd_val, rd_pfn;
  logic [SEL_W-1:0]     sel;
  logic [ISR_W-1:0]     isr;
  logic                 wr, rd, stat_zero;
  logic [DATA_W-1:0]    gf_q;
  logic [7:0]           status_q;

  assign wr        = req_valid && req_write;
  assign rd        = req_valid && !req_write;
  assign wmask     = width_mask(req_size);
  assign wval      = req_wdata & wmask;
  assign stat_zero = wr && kind == K_STATUS && wval[7:0] == 8'h00;

  pvq_decode #(.ADDR_W(ADDR_W), .CFG_LEN(CFG_LEN), .CFG_OFF_W(CFG_OFF_W)) u_dec (
    .addr(req_addr), .kind(kind), .cfg_off(cfg_off));

  pvq_queue_file #(.NQ(NQ), .SEL_W(SEL_W), .BASE_W(BASE_W)) u_qf (
    .clk(clk), .rst(rst), .clear(stat_zero),
    .wr_sel(wr && kind == K_QSEL), .wr_pfn(wr && kind == K_PFN),
    .wval(wval), .sel(sel), .rd_pfn(rd_pfn), .base(q_base_o));

  pvq_isr u_isr (
    .clk(clk), .rst(rst), .clear(stat_zero), .rd_clr(rd && kind == K_ISR),
    .set(isr_set_i), .isr(isr), .irq(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      gf_q <= '0; status_q <= '0;
      kick_o <= 1'b0; kick_idx_o <= '0; dev_reset_o <= 1'b0;
      rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      kick_o      <= wr && kind == K_KICK;
      dev_reset_o <= stat_zero;
      rsp_valid   <= rd;
      if (wr && kind == K_KICK) kick_idx_o <= wval[15:0];
      if (stat_zero)                        gf_q <= '0;
      else if (wr && kind == K_GUESTF)      gf_q <= wval;
      if (wr && kind == K_STATUS)           status_q <= wval[7:0];
      if (rd)                               rsp_rdata <= rd_val & wmask;
    end
  end

  always_comb begin
    case (kind)
      K_HOSTF:  rd_val = host_feat_i | (32'd1 << NOE_BIT);
      K_GUESTF: rd_val = gf_q;
      K_PFN:    rd_val = rd_pfn;
      K_QSIZE:  rd_val = 32'(q_size_i[sel*QSIZE_W +: QSIZE_W]);
      K_QSEL:   rd_val = 32'(sel);
      K_STATUS: rd_val = 32'(status_q);
      K_ISR:    rd_val = 32'(isr);
      K_CFG:    rd_val = cfg_rdata_i;
      default:  rd_val = '1;
    endcase
  end

  assign cfg_valid_o  = req_valid && kind == K_CFG;
  assign cfg_write_o  = req_write;
  assign cfg_off_o    = cfg_off;
  assign cfg_size_o   = req_size;
  assign cfg_wdata_o  = wval;
  assign guest_feat_o = gf_q;
  assign dev_status_o = status_q;

  // R12: holes in the map read as all ones at the access width
  assert_hole_ones_R12: assert property (@(posedge clk) disable iff (rst)
    (rd && kind == K_NONE) |=> rsp_rdata == width_mask($past(req_size)));
  // R9: zero status write pulses reset and clears features
  assert_zero_status_R9: assert property (@(posedge clk) disable iff (rst)
    stat_zero |=> dev_reset_o && guest_feat_o == '0 && irq_o == $past(isr_set_i[0]));
  // R7: doorbell write gives a one-cycle kick with the index
  assert_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && kind == K_KICK) |=> kick_o && kick_idx_o == $past(wval[15:0]));
  // R13: every read is answered on the next cycle
  assert_rsp_next_R13: assert property (@(posedge clk) disable iff (rst)
    rd |=> rsp_valid);
endmodule

// File: tb/pvq_regs_tb.sv
`timescale 1ns/1ps
module pvq_regs_tb;
  localparam int NQ = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [4:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid; logic [31:0] rsp_rdata;
  logic [31:0] host_feat = 32'h0000_1234;
  logic [NQ*16-1:0] q_size = {16'd1024, 16'd512, 16'd256, 16'd128};
  logic [7:0] isr_set = '0;
  logic cfg_valid, cfg_write; logic [2:0] cfg_off; logic [1:0] cfg_size;
  logic [31:0] cfg_wdata, cfg_rdata, guest_feat;
  logic [NQ*44-1:0] q_base;
  logic [7:0] dev_status; logic irq, kick, dev_reset; logic [15:0] kick_idx;

  int checks = 0, fails = 0;
  logic [31:0] m_gf = '0, m_pfn [NQ];
  int m_sel = 0; logic [7:0] m_status = '0, m_isr = '0;

  assign cfg_rdata = {8'hA5, 16'h0, 5'b0, cfg_off};

  pvq_regs u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .host_feat_i(host_feat),
    .q_size_i(q_size), .isr_set_i(isr_set), .cfg_valid_o(cfg_valid),
    .cfg_write_o(cfg_write), .cfg_off_o(cfg_off), .cfg_size_o(cfg_size),
    .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata), .guest_feat_o(guest_feat),
    .q_base_o(q_base), .dev_status_o(dev_status), .irq_o(irq), .kick_o(kick),
    .kick_idx_o(kick_idx), .dev_reset_o(dev_reset));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string r, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: got %h expected %h", r, got, exp); end
  endtask

  function automatic logic [31:0] msk(input logic [1:0] sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_rd(input int off);
    case (off)
      0:  return host_feat | 32'h0100_0000;
      4:  return m_gf;
      8:  return m_pfn[m_sel];
      12: return 32'(q_size[m_sel*16 +: 16]);
      14: return 32'(m_sel);
      18: return 32'(m_status);
      19: return 32'(m_isr);
      default: return (off >= 20 && off < 28) ? {8'hA5, 16'h0, 8'(off - 20)} : 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag(input int off);
    case (off)
      0: return "R2"; 4: return "R3"; 8: return "R4"; 12: return "R5";
      14: return "R6"; 16: return "R7"; 18: return "R8"; 19: return "R10";
      default: return (off >= 20 && off < 28) ? "R11" : "R12";
    endcase
  endfunction

  task automatic op(input bit w, input int off, input logic [1:0] sz,
                    input logic [31:0] d, input logic [7:0] s);
    logic [31:0] wv, exp;
    bit zero_st, clr;
    wv = d & msk(sz);
    exp = exp_rd(off) & msk(sz);
    zero_st = w && off == 18 && wv[7:0] == 0;
    req_valid = 1; req_write = w; req_addr = 5'(off); req_size = sz;
    req_wdata = d; isr_set = s;
    #1;
    if (off >= 20 && off < 28) begin
      check(cfg_valid && cfg_off == 3'(off - 20) && cfg_size == sz && cfg_write == w,
            "R11", {cfg_valid, cfg_off}, {1'b1, 3'(off - 20)});
      if (w) check(cfg_wdata == wv, "R13", cfg_wdata, wv);
    end else check(!cfg_valid, "R11", cfg_valid, 0);
    @(negedge clk);
    req_valid = 0; isr_set = '0;
    if (!w) begin
      check(rsp_valid, "R13", rsp_valid, 1);
      check(rsp_rdata == exp, tag(off), rsp_rdata, exp);
    end
    if (w) case (off)
      4:  m_gf = wv;
      8:  m_pfn[m_sel] = wv;
      14: if (wv < NQ) m_sel = int'(wv);
      18: m_status = wv[7:0];
      default: ;
    endcase
    clr = (!w && off == 19) || zero_st;
    m_isr = (clr ? 8'h00 : m_isr) | s;
    if (zero_st) begin
      m_gf = '0; m_sel = 0;
      for (int q = 0; q < NQ; q++) m_pfn[q] = '0;
    end
    check(kick == (w && off == 16), "R7", kick, w && off == 16);
    if (w && off == 16) check(kick_idx == wv[15:0], "R7", kick_idx, wv[15:0]);
    check(dev_reset == zero_st, "R9", dev_reset, zero_st);
    check(irq == m_isr[0], "R10", irq, m_isr[0]);
    check(guest_feat == m_gf, "R3", guest_feat, m_gf);
    check(dev_status == m_status, "R8", dev_status, m_status);
    for (int q = 0; q < NQ; q++)
      check(q_base[q*44 +: 44] == {m_pfn[q], 12'h0}, "R4", q_base[q*44 +: 44], {m_pfn[q], 12'h0});
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int q = 0; q < NQ; q++) m_pfn[q] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(!irq && !kick && !dev_reset && guest_feat == 0 && dev_status == 0 && q_base == '0,
          "R1", {irq, kick, dev_reset}, 0);
    op(0, 14, 2, 0, 0);
    op(0, 19, 0, 0, 0);
    // R2: forced bit, write ignored
    op(1, 0, 2, 32'hFFFF_FFFF, 0); op(0, 0, 2, 0, 0);
    host_feat = 32'h0100_00F0; op(0, 0, 1, 0, 0);
    // R3 and R13 narrow writes
    op(1, 4, 2, 32'hDEAD_BEEF, 0); op(1, 4, 0, 32'h1234_5678, 0); op(0, 4, 2, 0, 0);
    // R6 and R4: select, pfn, out-of-range select and pfn
    op(1, 14, 1, 2, 0); op(1, 8, 2, 32'h0000_0009, 0);
    op(1, 14, 2, 4, 0); op(0, 14, 2, 0, 0);
    op(1, 14, 2, 32'h0001_0001, 0); op(0, 14, 2, 0, 0);
    op(1, 8, 2, 32'h0000_0007, 0); op(0, 14, 2, 0, 0); op(0, 8, 2, 0, 0);
    // R5
    op(0, 12, 1, 0, 0); op(1, 12, 1, 16'hFFFF, 0); op(0, 12, 2, 0, 0);
    // R7 kick and doorbell read
    op(1, 16, 1, 32'h0003_0003, 0); op(0, 16, 1, 0, 0);
    // R10: set, read-clear, set wins, write ignored
    op(0, 4, 2, 0, 8'h05); op(1, 19, 0, 8'h00, 0); op(0, 19, 0, 0, 8'h01); op(0, 19, 0, 0, 0);
    // R11 and R12
    op(0, 20, 2, 0, 0); op(1, 27, 0, 32'h1FF, 0); op(0, 5, 1, 0, 0); op(0, 28, 2, 0, 0);
    op(1, 30, 2, 32'h55, 0); op(0, 1, 0, 0, 0);
    // R8 and R9: low byte zero resets
    op(1, 18, 2, 32'h0000_0107, 8'h02); op(0, 18, 2, 0, 0);
    op(1, 18, 2, 32'h0000_0F00, 0); op(0, 8, 2, 0, 0);
    // random mix
    for (int i = 0; i < 800; i++) begin
      int off; logic [31:0] d; logic [7:0] s;
      off = $urandom_range(0, 31);
      d = $urandom;
      if (off == 14) d = $urandom_range(0, 6);
      if (off == 18 && $urandom_range(0, 7) == 0) d[7:0] = 0;
      s = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      op($urandom_range(0, 1) == 1, off, 2'($urandom_range(0, 3)), d, s);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule